// File: doc/BRIEF.md
# Two-Word UART Frame Packer

This block sends asynchronous serial characters through a plain byte shifter that has no notion of start or stop bits. Each accepted 8-bit character is split across two 8-bit shift words. Those words carry idle ones, a start zero, the data bits sent least significant first, and one or two stop ones. The shifter runs without pause, one bit per divider tick. At every 8-bit word boundary it loads either the next pending word or an all-ones filler word. Because of this the line never repeats a stale bit and rests at logic one when nothing is queued.

A character arrives on a valid/ready byte port together with a layout select. The layout decides how idle, start, data and stop bits are shared between the two words. Once the first word of a pair enters the shifter, the second word is loaded at the very next word boundary, so each character goes out as one unbroken frame. Pairs may be separated by any number of filler words. The bit period is set in clock cycles by a programmable divider input. For example, 26666 cycles of an 8 MHz clock give roughly 300 bit/s, and smaller values give 2400 or 9600 bit/s.

Top module: `uart_word_packer`

## Requirements
- R1: After reset, ser_out is 1 and in_ready is 1.
- R2: With layout_sel = 0 the first word carries three idles, a start bit and d[3:0]; the second carries d[7:4], one stop and three idles. On the line this is start 0, d0..d7, and a stop 1.
- R3: With layout_sel = 1 the first word carries six idles, start and d0; the second carries d[7:1] and one stop. The line shows start 0, d0..d7, and one stop 1.
- R4: With layout_sel = 2 the first word carries five idles, start, d0 and d1; the second carries d[7:2] and two stops. The line shows start 0, d0..d7, and two stop 1 bits.
- R5: layout_sel = 3 produces the same frame as layout 0.
- R6: The second word of a pair is shifted in the bit period right after the last bit of the first word, so start, data and stop bits form one continuous frame.
- R7: When no pair is pending, the shifter loads all-ones words and ser_out stays at 1. It never repeats an earlier data or start bit.
- R8: Each bit lasts exactly div_value clock cycles. A div_value of 0 behaves as 1.
- R9: in_ready falls on the cycle after a byte is accepted and rises again only after that byte's second word has been loaded into the shifter.
- R10: ser_out is registered and changes only on the clock edge that ends a tick cycle.
- R11: Data and layout are captured at acceptance. Changes to in_data or layout_sel after that have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_value | input | DIV_W | Bit period in clock cycles (0 behaves as 1) |
| layout_sel | input | 2 | Framing layout for the byte being offered |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block can accept a byte |
| ser_out | output | 1 | Serial line, idle high |

## Verification
Characters are sent in every layout, and the receiving model samples at bit centres using the divider value in force. An error in any word's bit packing therefore shows up as a wrong data or stop bit. A character is queued while the previous one is still shifting, which exposes any gap inside a pair as a shifted frame; the all-zero and all-one characters catch bits lost at a word edge. Characters whose bit 0 is one allow the start-bit length to be measured exactly at divider values 4, 7, 1 and 0. A long quiet stretch at the end, with the input port wiggled after each acceptance, separates correct filler and capture from stale-bit repeats and late sampling of the inputs.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    typedef enum logic [1:0] {
        LAY_SPLIT_4_4  = 2'd0,
        LAY_SPLIT_1_7  = 2'd1,
        LAY_SPLIT_2_6S = 2'd2,
        LAY_ALIAS_4_4  = 2'd3
    } layout_e;

    typedef struct packed {
        logic [7:0] lead;
        logic [7:0] tail;
    } word_pair_t;

    typedef enum logic [1:0] {
        SEQ_EMPTY = 2'd0,
        SEQ_LEAD  = 2'd1,
        SEQ_TAIL  = 2'd2
    } seq_state_e;

    localparam logic [7:0] FILL_WORD = 8'hFF;

    // Bit 0 of each word leaves the shifter first.
    function automatic word_pair_t pack_pair(input logic [7:0] d, input layout_e lay);
        word_pair_t p;
        case (lay)
            LAY_SPLIT_1_7: begin
                p.lead = {d[0], 1'b0, 6'b111111};
                p.tail = {1'b1, d[7:1]};
            end
            LAY_SPLIT_2_6S: begin
                p.lead = {d[1:0], 1'b0, 5'b11111};
                p.tail = {2'b11, d[7:2]};
            end
            default: begin
                p.lead = {d[3:0], 4'b0111};
                p.tail = {4'b1111, d[7:4]};
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pkt_tick_gen.sv
module pkt_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = (div_i == '0) ? '0 : div_i - 1'b1;
        tick_o = (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R8: with a period above one cycle, ticks never come on adjacent cycles
    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i > 1) |=> (!tick_o || div_i <= 1));

endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
    import pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    input  logic [1:0] layout_i,
    output logic       in_ready_o,
    input  logic       take_i,
    output logic       word_valid_o,
    output logic [7:0] word_o
);
    seq_state_e state_q;
    word_pair_t pair_q;

    always_comb begin
        in_ready_o   = (state_q == SEQ_EMPTY);
        word_valid_o = (state_q != SEQ_EMPTY);
        word_o       = (state_q == SEQ_TAIL) ? pair_q.tail : pair_q.lead;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_EMPTY;
            pair_q  <= '{lead: FILL_WORD, tail: FILL_WORD};
        end else begin
            case (state_q)
                SEQ_EMPTY: if (in_valid_i) begin
                    pair_q  <= pack_pair(in_data_i, layout_e'(layout_i));
                    state_q <= SEQ_LEAD;
                end
                SEQ_LEAD:  if (take_i) state_q <= SEQ_TAIL;
                SEQ_TAIL:  if (take_i) state_q <= SEQ_EMPTY;
                default:   state_q <= SEQ_EMPTY;
            endcase
        end
    end

    // R9: acceptance blocks further input on the next cycle
    a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R9: input reopens only right after the shifter took a word
    a_r9_ready_after_take: assert property (@(posedge clk) disable iff (rst)
        (!in_ready_o ##1 in_ready_o) |-> $past(take_i));

endmodule

// File: rtl/pkt_word_shifter.sv
module pkt_word_shifter
    import pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       word_valid_i,
    input  logic [7:0] word_i,
    output logic       take_o,
    output logic       ser_o
);
    logic [7:0] sreg_q;
    logic [2:0] left_q;
    logic [7:0] load_word;
    logic       at_edge;

    always_comb begin
        at_edge   = (left_q == '0);
        take_o    = tick_i && at_edge && word_valid_i;
        load_word = word_valid_i ? word_i : FILL_WORD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= FILL_WORD;
            left_q <= '0;
            ser_o  <= 1'b1;
        end else if (tick_i) begin
            if (at_edge) begin
                ser_o  <= load_word[0];
                sreg_q <= {1'b1, load_word[7:1]};
                left_q <= 3'd7;
            end else begin
                ser_o  <= sreg_q[0];
                sreg_q <= {1'b1, sreg_q[7:1]};
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R10: the line holds its value through every non-tick cycle
    a_r10_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(ser_o));

endmodule

// File: rtl/uart_word_packer.sv
module uart_word_packer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_value,
    input  logic [1:0]       layout_sel,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             ser_out
);
    logic       tick;
    logic       take;
    logic       word_valid;
    logic [7:0] word;

    pkt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_value),
        .tick_o (tick)
    );

    pkt_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .in_valid_i   (in_valid),
        .in_data_i    (in_data),
        .layout_i     (layout_sel),
        .in_ready_o   (in_ready),
        .take_i       (take),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    pkt_word_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .word_valid_i (word_valid),
        .word_i       (word),
        .take_o       (take),
        .ser_o        (ser_out)
    );

endmodule

// File: tb/tb_uart_word_packer.sv
module tb_uart_word_packer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_value = 16'd4;
    logic [1:0]       layout_sel = 2'd0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_ready;
    logic             ser_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_busy = 0;
    bit finished = 0;

    typedef struct { logic [7:0] d; int lay; } item_t;
    item_t exp_q[$];

    uart_word_packer #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .div_value(div_value), .layout_sel(layout_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .ser_out(ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_div();
        return (div_value == 0) ? 1 : int'(div_value);
    endfunction

    // Driver: offer a byte, record it, then disturb the input port.
    task automatic send(input logic [7:0] d, input int lay);
        @(negedge clk);
        in_valid   = 1'b1;
        in_data    = d;
        layout_sel = lay[1:0];
        while (in_ready !== 1'b1) @(negedge clk);
        exp_q.push_back('{d: d, lay: lay});
        @(negedge clk);
        in_valid   = 1'b0;
        in_data    = ~d;              // R11: must not reach the frame
        layout_sel = 2'(lay + 1);
        check(in_ready === 1'b0, "R9 ready low after accept", in_ready, 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (20 * eff_div()) @(negedge clk);
    endtask

    // Monitor: decode the line at bit centres and compare with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ser_out === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7 line low with nothing queued", ser_out, 1);
                    while (ser_out !== 1'b1) @(negedge clk);
                end else begin
                    item_t it;
                    int ed, nb, stops, cnt, first_high;
                    logic [10:0] got, expv;
                    string tag;
                    mon_busy = 1;
                    it    = exp_q.pop_front();
                    ed    = eff_div();
                    stops = (it.lay == 2) ? 2 : 1;
                    nb    = 9 + stops;
                    got   = '1;
                    expv  = '1;
                    expv[0]   = 1'b0;
                    expv[8:1] = it.d;
                    cnt = 0;
                    first_high = -1;
                    while (cnt < nb * ed) begin
                        if (ser_out === 1'b1 && first_high < 0) first_high = cnt;
                        if (cnt % ed == ed / 2) got[cnt / ed] = ser_out;
                        cnt++;
                        if (cnt < nb * ed) @(negedge clk);
                    end
                    case (it.lay)
                        1: tag = "R3 R6 R11 frame layout1";
                        2: tag = "R4 R6 R11 frame layout2";
                        3: tag = "R5 R6 R11 frame layout3";
                        default: tag = "R2 R6 R11 frame layout0";
                    endcase
                    check(got === expv, tag, got, expv);
                    if (it.d[0])
                        check(first_high == ed, "R8 R10 start bit length", first_high, ed);
                    mon_busy = 0;
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(ser_out === 1'b1, "R1 line high after reset", ser_out, 1);
        check(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);

        div_value = 16'd4;
        send(8'hA5, 0);
        send(8'h3C, 1);
        send(8'hF0, 2);
        send(8'h81, 3);
        send(8'h55, 0);
        drain();

        div_value = 16'd7;
        send(8'h01, 2);
        send(8'hFF, 1);
        send(8'h00, 0);
        send(8'hB7, 3);
        drain();

        div_value = 16'd0;
        send(8'h5B, 0);
        send(8'h6D, 2);
        send(8'h93, 1);
        drain();

        div_value = 16'd1;
        send(8'hC3, 2);
        send(8'h2F, 0);
        drain();

        div_value = 16'd3;
        lows = 0;
        repeat (200) begin
            @(negedge clk);
            if (ser_out !== 1'b1) lows++;
        end
        check(lows == 0, "R7 idle line stays high", lows, 0);
        check(in_ready === 1'b1, "R9 ready back after pair", in_ready, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule